// File: doc/BRIEF.md
# Per-Type Adaptive Variable-Node Deactivation Controller

This block sits beside the variable-node array of an iterative LDPC decoder and decides, once per decoding iteration, which variable nodes skip their update. Every node carries a small type index, and every type owns a reliability threshold. A node whose a-posteriori LLR magnitude has reached its type's threshold is flagged as deactivated; the others remain active and keep computing.

Thresholds are not fixed for the whole codeword. A short chain of estimator stages watches how many nodes get deactivated in each iteration. Every iteration whose deactivated count exceeds a programmable limit sets one more stage. When the selected number of stages is full, the estimator fires and then clears. Each firing raises every type's threshold by a programmable step, which lets nodes that were switched off too early resume their updates. The number of raises per codeword is capped.

The decoder pulses `cwStart` with the initial thresholds on `initThr` at the start of each codeword. It pulses `iterStrobe` once per iteration with the node magnitudes and types presented, and pulses `earlyStop` when decoding ends before the iteration limit.

Top module: `vn_deact_ctrl`

## Requirements
- R1: After reset, and in the cycle after `cwStart`, every bit of `deactFlags` is 0. `cwStart` reloads each type's threshold from `initThr` (type t in bits [t*6 +: 6]) and clears the estimator stages, the raise count, the iteration count and the stop state. It takes priority over every other input.
- R2: In the cycle after an accepted `iterStrobe`, bit i of `deactFlags` is 1 exactly when node i's magnitude (`nodeMag` bits [i*6 +: 6]) is greater than or equal to the threshold of its type (`nodeType` bits [i*2 +: 2]), as that threshold stands after any raise in the same iteration.
- R3: Each of the four types uses its own threshold. Nodes with equal magnitudes but different types can receive different flags.
- R4: The deactivated count of an iteration is taken against the thresholds held before that iteration. An iteration whose count is strictly greater than `rateLimit` sets one further estimator stage. The estimator fires in the iteration where the last selected stage becomes set, and all stages then clear.
- R5: A firing with raises left adds `thrStep` to every type's threshold. The result saturates at 63.
- R6: In the iteration of a raise, a node whose magnitude is below its type's raised threshold gets flag 0, even if it was flagged before.
- R7: At most `trialMax` raises happen per codeword. Once the cap is reached, further firings still clear the stages but leave the thresholds unchanged.
- R8: At most 20 strobes are accepted per codeword. Later strobes leave the flags unchanged.
- R9: In the cycle after `earlyStop` (without `cwStart`), every flag is 1. The flags stay at 1, and strobes are ignored, until the next `cwStart`.
- R10: In a cycle with none of `cwStart`, `earlyStop` or `iterStrobe`, the flags hold their value.
- R11: `numStages` selects the estimator length. A value of 3 fires on the third over-limit iteration and a value of 4 on the fourth. Values below 1 act as 1, and values above 4 act as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cwStart | input | 1 | Start of codeword: load thresholds, clear state |
| earlyStop | input | 1 | Decoding ended early: force all nodes off |
| iterStrobe | input | 1 | One pulse per decoding iteration |
| initThr | input | 24 | Initial threshold per type, 6 bits each |
| thrStep | input | 6 | Amount added to each threshold per raise |
| rateLimit | input | 5 | Deactivated-count limit for setting a stage |
| numStages | input | 3 | Estimator length (3 or 4 in normal use) |
| trialMax | input | 3 | Maximum raises per codeword |
| nodeMag | input | 96 | LLR magnitude per node, 6 bits each |
| nodeType | input | 32 | Type index per node, 2 bits each |
| deactFlags | output | 16 | 1 = node deactivated, 0 = active |

## Verification
Every cycle, the assertions check the flag clearing after a codeword start and the all-ones flags after an early stop. They also check that the flags hold in idle cycles, that the iteration count never passes its cap, that thresholds never fall within a codeword, and that each raise advances the raise count by one. The stage counting, the exact iteration in which a raise happens, saturation at 63, the reactivation of nodes after a raise and the behaviour once raises run out depend on magnitude sequences across iterations. Only the bench's scenarios, compared against its behavioural model, can show these.

// File: rtl/vn_deact_pkg.sv
`timescale 1ns/1ps
package vn_deact_pkg;
  // strobes issued by the control toward the datapath
  typedef struct packed {
    logic loadInit;
    logic evalIter;
    logic raiseThr;
    logic forceAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/vn_deact_datapath.sv
`timescale 1ns/1ps
module vn_deact_datapath
  import vn_deact_pkg::*;
#(
  parameter int NUM_NODES = 16,
  parameter int NUM_TYPES = 4,
  parameter int MAG_W     = 6,
  parameter int TYPE_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
  parameter int CNT_W     = $clog2(NUM_NODES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrlStrobes_t                 strobes,
  input  logic [NUM_TYPES*MAG_W-1:0]   initThr,
  input  logic [MAG_W-1:0]             thrStep,
  input  logic [NUM_NODES*MAG_W-1:0]   nodeMag,
  input  logic [NUM_NODES*TYPE_W-1:0]  nodeType,
  output logic [CNT_W-1:0]             deactCount,
  output logic [NUM_NODES-1:0]         deactFlags,
  output logic [NUM_TYPES*MAG_W-1:0]   thrFlat
);

  logic [NUM_TYPES-1:0][MAG_W-1:0] thrReg;
  logic [NUM_TYPES-1:0][MAG_W-1:0] thrRaised;
  logic [NUM_TYPES-1:0][MAG_W-1:0] thrNext;
  logic [NUM_NODES-1:0]            curHit;
  logic [NUM_NODES-1:0]            nextHit;

  // saturating raise per type
  always_comb begin
    for (int t = 0; t < NUM_TYPES; t++) begin
      logic [MAG_W:0] sum;
      sum = {1'b0, thrReg[t]} + {1'b0, thrStep};
      thrRaised[t] = sum[MAG_W] ? {MAG_W{1'b1}} : sum[MAG_W-1:0];
      thrNext[t]   = strobes.raiseThr ? thrRaised[t] : thrReg[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thrReg <= '0;
    end else if (strobes.loadInit) begin
      for (int t = 0; t < NUM_TYPES; t++) thrReg[t] <= initThr[t*MAG_W +: MAG_W];
    end else if (strobes.raiseThr) begin
      thrReg <= thrRaised;
    end
  end

  // per-node comparison against the node's type threshold
  for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
    logic [TYPE_W-1:0] typ;
    logic [TYPE_W-1:0] tIdx;
    logic [MAG_W-1:0]  mag;
    assign typ  = nodeType[i*TYPE_W +: TYPE_W];
    assign tIdx = ({1'b0, typ} < (TYPE_W+1)'(NUM_TYPES)) ? typ : '0;
    assign mag  = nodeMag[i*MAG_W +: MAG_W];
    assign curHit[i]  = (mag >= thrReg[tIdx]);
    assign nextHit[i] = (mag >= thrNext[tIdx]);
  end

  // deactivation count against the thresholds in force this iteration
  always_comb begin
    deactCount = '0;
    for (int i = 0; i < NUM_NODES; i++) deactCount = deactCount + CNT_W'(curHit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  deactFlags <= '0;
    else if (strobes.loadInit)   deactFlags <= '0;
    else if (strobes.forceAll)   deactFlags <= '1;
    else if (strobes.evalIter)   deactFlags <= nextHit;
  end

  always_comb begin
    for (int t = 0; t < NUM_TYPES; t++) thrFlat[t*MAG_W +: MAG_W] = thrReg[t];
  end

endmodule

// File: rtl/vn_deact_control.sv
`timescale 1ns/1ps
module vn_deact_control
  import vn_deact_pkg::*;
#(
  parameter int NUM_NODES  = 16,
  parameter int MAX_ITER   = 20,
  parameter int MAX_STAGES = 4,
  parameter int TRIAL_W    = 3,
  parameter int CNT_W      = $clog2(NUM_NODES + 1),
  parameter int STG_W      = $clog2(MAX_STAGES + 1),
  parameter int ITER_W     = $clog2(MAX_ITER + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cwStart,
  input  logic               earlyStop,
  input  logic               iterStrobe,
  input  logic [CNT_W-1:0]   deactCount,
  input  logic [CNT_W-1:0]   rateLimit,
  input  logic [STG_W-1:0]   numStages,
  input  logic [TRIAL_W-1:0] trialMax,
  output ctrlStrobes_t       strobes,
  output logic [ITER_W-1:0]  iterCnt,
  output logic [TRIAL_W-1:0] trialCnt
);

  logic [MAX_STAGES-1:0] stageReg;
  logic [MAX_STAGES-1:0] stageNext;
  logic                  stopped;
  logic                  evalOk;
  logic                  overRate;
  logic                  fire;
  logic                  trigger;
  logic                  raise;
  int                    lastIdx;

  assign evalOk   = iterStrobe && !cwStart && !earlyStop && !stopped &&
                    (iterCnt < ITER_W'(MAX_ITER));
  assign overRate = deactCount > rateLimit;
  assign stageNext = overRate ? {stageReg[MAX_STAGES-2:0], 1'b1} : stageReg;

  // estimator length, clamped to the built stage count
  always_comb begin
    lastIdx = int'(numStages) - 1;
    if (lastIdx < 0) lastIdx = 0;
    if (lastIdx > MAX_STAGES - 1) lastIdx = MAX_STAGES - 1;
    fire = 1'b0;
    for (int k = 0; k < MAX_STAGES; k++) begin
      if (k == lastIdx) fire = stageNext[k];
    end
  end

  assign trigger = evalOk && fire;
  assign raise   = trigger && (trialCnt < trialMax);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageReg <= '0;
      trialCnt <= '0;
      iterCnt  <= '0;
      stopped  <= 1'b0;
    end else if (cwStart) begin
      stageReg <= '0;
      trialCnt <= '0;
      iterCnt  <= '0;
      stopped  <= 1'b0;
    end else if (earlyStop) begin
      stopped  <= 1'b1;
    end else if (evalOk) begin
      iterCnt  <= iterCnt + ITER_W'(1);
      stageReg <= trigger ? '0 : stageNext;
      if (raise) trialCnt <= trialCnt + TRIAL_W'(1);
    end
  end

  always_comb begin
    strobes.loadInit = cwStart;
    strobes.forceAll = earlyStop && !cwStart;
    strobes.evalIter = evalOk;
    strobes.raiseThr = raise;
  end

endmodule

// File: rtl/vn_deact_ctrl.sv
`timescale 1ns/1ps
module vn_deact_ctrl
  import vn_deact_pkg::*;
#(
  parameter int NUM_NODES  = 16,
  parameter int NUM_TYPES  = 4,
  parameter int MAG_W      = 6,
  parameter int MAX_ITER   = 20,
  parameter int MAX_STAGES = 4,
  parameter int TRIAL_W    = 3,
  parameter int TYPE_W     = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
  parameter int CNT_W      = $clog2(NUM_NODES + 1),
  parameter int STG_W      = $clog2(MAX_STAGES + 1),
  parameter int ITER_W     = $clog2(MAX_ITER + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cwStart,
  input  logic                        earlyStop,
  input  logic                        iterStrobe,
  input  logic [NUM_TYPES*MAG_W-1:0]  initThr,
  input  logic [MAG_W-1:0]            thrStep,
  input  logic [CNT_W-1:0]            rateLimit,
  input  logic [STG_W-1:0]            numStages,
  input  logic [TRIAL_W-1:0]          trialMax,
  input  logic [NUM_NODES*MAG_W-1:0]  nodeMag,
  input  logic [NUM_NODES*TYPE_W-1:0] nodeType,
  output logic [NUM_NODES-1:0]        deactFlags
);

  ctrlStrobes_t              strobes;
  logic [CNT_W-1:0]          deactCount;
  logic [ITER_W-1:0]         iterCnt;
  logic [TRIAL_W-1:0]        trialCnt;
  logic [NUM_TYPES*MAG_W-1:0] thrFlat;

  vn_deact_control #(
    .NUM_NODES(NUM_NODES), .MAX_ITER(MAX_ITER), .MAX_STAGES(MAX_STAGES),
    .TRIAL_W(TRIAL_W), .CNT_W(CNT_W), .STG_W(STG_W), .ITER_W(ITER_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cwStart(cwStart), .earlyStop(earlyStop),
    .iterStrobe(iterStrobe), .deactCount(deactCount), .rateLimit(rateLimit),
    .numStages(numStages), .trialMax(trialMax), .strobes(strobes),
    .iterCnt(iterCnt), .trialCnt(trialCnt)
  );

  vn_deact_datapath #(
    .NUM_NODES(NUM_NODES), .NUM_TYPES(NUM_TYPES), .MAG_W(MAG_W),
    .TYPE_W(TYPE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .initThr(initThr),
    .thrStep(thrStep), .nodeMag(nodeMag), .nodeType(nodeType),
    .deactCount(deactCount), .deactFlags(deactFlags), .thrFlat(thrFlat)
  );

endmodule

// File: rtl/vn_deact_ctrl_chk.sv
`timescale 1ns/1ps
module vn_deact_ctrl_chk
  import vn_deact_pkg::*;
#(
  parameter int NUM_NODES = 16,
  parameter int NUM_TYPES = 4,
  parameter int MAG_W     = 6,
  parameter int MAX_ITER  = 20,
  parameter int TRIAL_W   = 3,
  parameter int ITER_W    = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cwStart,
  input logic                       earlyStop,
  input logic                       iterStrobe,
  input logic [NUM_NODES-1:0]       deactFlags,
  input ctrlStrobes_t               strobes,
  input logic [ITER_W-1:0]          iterCnt,
  input logic [TRIAL_W-1:0]         trialCnt,
  input logic [NUM_TYPES*MAG_W-1:0] thrFlat
);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cwStart |=> (deactFlags == '0));

  a_r9_stop_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    (earlyStop && !cwStart) |=> (deactFlags == {NUM_NODES{1'b1}}));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cwStart && !earlyStop && !iterStrobe) |=> $stable(deactFlags));

  a_r8_iter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    iterCnt <= ITER_W'(MAX_ITER));

  a_r8_no_eval_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (iterCnt == ITER_W'(MAX_ITER)) |-> !strobes.evalIter);

  a_r7_raise_counts: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.raiseThr |=> (trialCnt == $past(trialCnt) + TRIAL_W'(1)));

  a_r4_raise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.raiseThr |-> iterStrobe);

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_mono
    a_r5_thr_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
      !cwStart |=> (thrFlat[t*MAG_W +: MAG_W] >= $past(thrFlat[t*MAG_W +: MAG_W])));
  end

endmodule

bind vn_deact_ctrl vn_deact_ctrl_chk #(
  .NUM_NODES(NUM_NODES), .NUM_TYPES(NUM_TYPES), .MAG_W(MAG_W),
  .MAX_ITER(MAX_ITER), .TRIAL_W(TRIAL_W), .ITER_W(ITER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cwStart(cwStart), .earlyStop(earlyStop),
  .iterStrobe(iterStrobe), .deactFlags(deactFlags), .strobes(strobes),
  .iterCnt(iterCnt), .trialCnt(trialCnt), .thrFlat(thrFlat)
);

// File: tb/sim_vn_deact_ctrl.sv
`timescale 1ns/1ps
module sim_vn_deact_ctrl;

  localparam int N  = 16;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cwStart = 1'b0, earlyStop = 1'b0, iterStrobe = 1'b0;
  logic [NT*6-1:0] initThr;
  logic [5:0]      thrStep;
  logic [4:0]      rateLimit;
  logic [2:0]      numStages;
  logic [2:0]      trialMax;
  logic [N*6-1:0]  nodeMag;
  logic [N*2-1:0]  nodeType;
  logic [N-1:0]    deactFlags;

  int initV[NT];
  int stepV, rateV, stgV, trialV;
  int mag[N];
  int typ[N];

  // reference model state
  int mThr[NT];
  logic [N-1:0] mFlags;
  int mStages, mTrials, mIter;
  bit mStopped;

  int checks = 0, fails = 0;
  string curReq = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) initThr[t*6 +: 6] = 6'(initV[t]);
    for (int i = 0; i < N; i++) begin
      nodeMag[i*6 +: 6] = 6'(mag[i]);
      nodeType[i*2 +: 2] = 2'(typ[i]);
    end
    thrStep   = 6'(stepV);
    rateLimit = 5'(rateV);
    numStages = 3'(stgV);
    trialMax  = 3'(trialV);
  end

  vn_deact_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cwStart(cwStart), .earlyStop(earlyStop),
    .iterStrobe(iterStrobe), .initThr(initThr), .thrStep(thrStep),
    .rateLimit(rateLimit), .numStages(numStages), .trialMax(trialMax),
    .nodeMag(nodeMag), .nodeType(nodeType), .deactFlags(deactFlags)
  );

  task automatic modelStep();
    int cnt, ns;
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) mThr[t] = 0;
      mFlags = '0; mStages = 0; mTrials = 0; mIter = 0; mStopped = 0;
    end else if (cwStart) begin
      for (int t = 0; t < NT; t++) mThr[t] = initV[t];
      mFlags = '0; mStages = 0; mTrials = 0; mIter = 0; mStopped = 0;
    end else if (earlyStop) begin
      mStopped = 1; mFlags = '1;
    end else if (iterStrobe && !mStopped && mIter < 20) begin
      cnt = 0;
      for (int i = 0; i < N; i++) if (mag[i] >= mThr[typ[i]]) cnt++;
      mIter++;
      if (cnt > rateV) mStages++;
      ns = (stgV < 1) ? 1 : ((stgV > 4) ? 4 : stgV);
      if (mStages >= ns) begin
        mStages = 0;
        if (mTrials < trialV) begin
          mTrials++;
          for (int t = 0; t < NT; t++) mThr[t] = (mThr[t] + stepV > 63) ? 63 : mThr[t] + stepV;
        end
      end
      for (int i = 0; i < N; i++) mFlags[i] = (mag[i] >= mThr[typ[i]]);
    end
  endtask

  task automatic compare();
    checks++;
    if (deactFlags !== mFlags) begin
      fails++;
      $display("FAIL %s: deactFlags actual %h expected %h at %0t", curReq, deactFlags, mFlags, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic startCw();
    cwStart = 1'b1; tick(); cwStart = 1'b0;
  endtask

  task automatic strobe();
    iterStrobe = 1'b1; tick(); iterStrobe = 1'b0;
  endtask

  task automatic setMagPerType(int d0, int d1, int d2, int d3);
    for (int i = 0; i < N; i++) begin
      case (typ[i])
        0: mag[i] = d0;
        1: mag[i] = d1;
        2: mag[i] = d2;
        default: mag[i] = d3;
      endcase
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    summary();
  end

  initial begin
    initV[0] = 10; initV[1] = 20; initV[2] = 30; initV[3] = 40;
    stepV = 8; rateV = 16; stgV = 3; trialV = 2;
    for (int i = 0; i < N; i++) begin typ[i] = i % NT; mag[i] = 0; end

    // R1: reset state
    curReq = "R1";
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    tick();
    startCw();

    // R2 / R3: per-type comparisons, estimator never triggered
    curReq = "R3";
    for (int i = 0; i < N; i++) mag[i] = 25;
    strobe();
    curReq = "R2";
    for (int i = 0; i < N; i++) mag[i] = (i * 5 + 3 > 63) ? 63 : i * 5 + 3;
    strobe();
    setMagPerType(10, 19, 30, 39);
    strobe();
    setMagPerType(9, 20, 29, 40);
    strobe();

    // R10: idle cycles hold flags while magnitudes change
    curReq = "R10";
    setMagPerType(63, 0, 63, 0);
    tick(); tick();

    // R4 / R6: three over-limit iterations raise, then reactivation
    curReq = "R4";
    startCw();
    rateV = 4;
    setMagPerType(12, 22, 32, 42);
    strobe(); strobe();
    curReq = "R6";
    strobe();
    strobe();

    // R7: raises run out after trialMax
    curReq = "R7";
    setMagPerType(63, 63, 63, 63);
    for (int k = 0; k < 10; k++) strobe();

    // R8: iteration cap of 20
    curReq = "R8";
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < N; i++) mag[i] = int'($urandom_range(63, 0));
      strobe();
    end

    // R11: four-stage estimator; R5: saturation at 63
    curReq = "R11";
    stgV = 4; stepV = 30; trialV = 7; rateV = 2;
    startCw();
    setMagPerType(45, 50, 55, 62);
    strobe(); strobe(); strobe();
    strobe();
    curReq = "R5";
    setMagPerType(63, 63, 63, 63);
    for (int k = 0; k < 8; k++) strobe();
    setMagPerType(62, 63, 62, 63);
    strobe();

    // R11: out-of-range stage counts clamp
    curReq = "R11";
    stgV = 0; stepV = 5; trialV = 3; rateV = 0;
    startCw();
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < N; i++) mag[i] = int'($urandom_range(63, 0));
      strobe();
    end
    stgV = 7;
    startCw();
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < N; i++) mag[i] = int'($urandom_range(63, 0));
      strobe();
    end

    // R9: early stop forces all off and blocks strobes
    curReq = "R9";
    stgV = 3; rateV = 8; stepV = 4; trialV = 2;
    startCw();
    setMagPerType(5, 5, 5, 5);
    strobe();
    earlyStop = 1'b1; tick(); earlyStop = 1'b0;
    strobe(); strobe();
    tick();

    // R1: codeword start wins over simultaneous inputs
    curReq = "R1";
    cwStart = 1'b1; earlyStop = 1'b1; iterStrobe = 1'b1;
    tick();
    cwStart = 1'b0; earlyStop = 1'b0; iterStrobe = 1'b0;
    curReq = "R2";
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < N; i++) mag[i] = int'($urandom_range(63, 0));
      strobe();
    end

    summary();
  end

endmodule